// File: doc/BRIEF.md
# Serial-Mapped Open-Drain Signaling Pin Bridge

This block links two general-purpose signaling bits in a 64-bit serial word to two bidirectional open-drain pins. On the receive side it takes the two signaling bits out of the incoming word and, a few bit periods later, turns them into pull-down enables for the pins. On the transmit side it samples the pin levels a fixed number of bit periods before the outgoing word needs them, and hands the pair to the transmit shifter. The bits carry no meaning inside the block. They only pass signaling between the serial stream and the board.

The serial word has two layouts, selected by a mode input: a data word and a control word. Each layout puts the signaling field, the pin sampling point and the pin drive point at its own bit index. The bit index counts down from 63 to 0 as the word goes by. The pins are sampled on the rising serial clock edge. Serial input bits are captured, and the pins are driven, on the falling edge. The pins accept new values from data words only. In a control word the signaling field is ignored.

Incoming bits wait in a shadow register until the drive point, so the pins change only at that one falling edge. Because the pins are open-drain, a 1 releases the pin. An external device can still hold a released pin low, and the level read back then differs from the value written.

Top module: `serial_pio_bridge`

## Requirements
- R1: While reset is low, and right after it, both pull-down enables are 0 (pins released) and both transmit bits are 1.
- R2: In a data word (ctrl_mode = 0), the sensed pin levels are copied to tx_pio on the rising clock edge that ends the slot with bit index 20. tx_pio[1] carries pin 1 and tx_pio[0] carries pin 0.
- R3: In a control word (ctrl_mode = 1), the sensed pin levels are copied to tx_pio on the rising edge that ends the slot with bit index 36.
- R4: tx_pio does not change on any rising edge other than the sampling slot of the current mode, even when the pin levels change.
- R5: In a data word, the serial input bit is captured on the falling edge: bit index 15 gives pin 1 and bit index 14 gives pin 0.
- R6: In a control word, the serial bits at indices 31 (pin 1) and 30 (pin 0) are ignored, and the pull-down enables keep their values.
- R7: pd_en changes only on the falling edge in the drive slot. For a data word this is bit index 8, so pd_en is unchanged in the slots from 13 down to 9.
- R8: A written 1 releases its pin (pd_en = 0) and a written 0 pulls it low (pd_en = 1). A released pin that an external device holds low is sampled as 0.
- R9: A write captured in a data word that is still pending when the word is cut short is driven at the control-mode drive slot (bit index 24) of a following control word, and not before that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial bit clock. Pins are sampled on its rising edge; serial input is captured and pins are driven on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_mode | input | 1 | Word layout: 0 = data word, 1 = control word |
| bit_idx | input | 6 | Index of the current bit slot, counting down from 63 to 0 |
| sdin | input | 1 | Serial input bit of the current slot |
| pin_sense | input | 2 | Sensed levels of the two open-drain pins |
| pd_en | output | 2 | Pull-down enable per pin; 1 drives the pin low |
| tx_pio | output | 2 | Sampled pin levels for the transmit shifter |

## Verification
A bad shadow bit or a stuck pending flag does not show up at once. It appears only at the next drive slot, as a wrong pd_en value, and so it becomes visible within one word. The table therefore checks pd_en at the end of every word, and it checks pd_en one slot before and one slot after each drive point. A wrong sample position shows in tx_pio at the next word boundary. Pin levels are changed after the sampling point so that a sample taken in the wrong slot gives a different value from a correct one. Reset is applied in the middle of the run as well as at the start.

// File: rtl/spio_pkg.sv
`timescale 1ns/1ps
package spio_pkg;

    typedef enum logic {
        MODE_DATA = 1'b0,
        MODE_CTRL = 1'b1
    } spio_mode_e;

    // Default slot positions (bit index counts down through the word)
    localparam int SAMP_DATA_DEF   = 20;
    localparam int SAMP_CTRL_DEF   = 36;
    localparam int WR_DATA_TOP_DEF = 15;
    localparam int WR_CTRL_TOP_DEF = 31;
    localparam int DRV_DATA_DEF    = 8;
    localparam int DRV_CTRL_DEF    = 24;

endpackage

// File: rtl/spio_pos_decode.sv
`timescale 1ns/1ps
module spio_pos_decode #(
    parameter int IDX_W       = 6,
    parameter int NPIO        = 2,
    parameter int SAMP_DATA   = 20,
    parameter int SAMP_CTRL   = 36,
    parameter int WR_DATA_TOP = 15,
    parameter int WR_CTRL_TOP = 31,
    parameter int DRV_DATA    = 8,
    parameter int DRV_CTRL    = 24
) (
    input  logic             ctrl_mode,
    input  logic [IDX_W-1:0] bit_idx,
    output logic             hit_samp,
    output logic             hit_drive,
    output logic [NPIO-1:0]  hit_wr
);
    import spio_pkg::*;

    localparam logic [IDX_W-1:0] SAMP_D = IDX_W'(SAMP_DATA);
    localparam logic [IDX_W-1:0] SAMP_C = IDX_W'(SAMP_CTRL);
    localparam logic [IDX_W-1:0] DRV_D  = IDX_W'(DRV_DATA);
    localparam logic [IDX_W-1:0] DRV_C  = IDX_W'(DRV_CTRL);

    spio_mode_e mode;
    assign mode = spio_mode_e'(ctrl_mode);

    always_comb begin
        hit_samp  = (bit_idx == ((mode == MODE_CTRL) ? SAMP_C : SAMP_D));
        hit_drive = (bit_idx == ((mode == MODE_CTRL) ? DRV_C : DRV_D));
    end

    // Highest pin sits at the top slot of the field, lower pins follow
    for (genvar i = 0; i < NPIO; i++) begin : g_wr
        localparam logic [IDX_W-1:0] POS_D = IDX_W'(WR_DATA_TOP - (NPIO - 1 - i));
        localparam logic [IDX_W-1:0] POS_C = IDX_W'(WR_CTRL_TOP - (NPIO - 1 - i));
        assign hit_wr[i] = (bit_idx == ((mode == MODE_CTRL) ? POS_C : POS_D));
    end

endmodule

// File: rtl/spio_pin_sampler.sv
`timescale 1ns/1ps
module spio_pin_sampler #(
    parameter int NPIO = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            take,
    input  logic [NPIO-1:0] pin_sense,
    output logic [NPIO-1:0] tx_pio
);
    typedef struct packed {
        logic [NPIO-1:0] tx;
    } samp_t;

    samp_t samp_d, samp_q;

    always_comb begin
        samp_d = samp_q;
        if (take) begin
            samp_d.tx = pin_sense;
        end
    end

    // Rising edge: the only place pin levels are read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            samp_q.tx <= '1;
        end else begin
            samp_q <= samp_d;
        end
    end

    assign tx_pio = samp_q.tx;

endmodule

// File: rtl/spio_shadow_drive.sv
`timescale 1ns/1ps
module spio_shadow_drive #(
    parameter int NPIO = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_mode,
    input  logic [NPIO-1:0] hit_wr,
    input  logic            hit_drive,
    input  logic            sdin,
    output logic [NPIO-1:0] pd_en
);
    import spio_pkg::*;

    typedef struct packed {
        logic [NPIO-1:0] shadow;
        logic            pend;
        logic [NPIO-1:0] pd;
    } drv_t;

    drv_t drv_d, drv_q;
    logic wr_ok;

    assign wr_ok = (spio_mode_e'(ctrl_mode) == MODE_DATA);

    always_comb begin
        drv_d = drv_q;
        if (wr_ok) begin
            for (int i = 0; i < NPIO; i++) begin
                if (hit_wr[i]) begin
                    drv_d.shadow[i] = sdin;
                end
            end
            // Pin 0 is the last bit of the field: write complete
            if (hit_wr[0]) begin
                drv_d.pend = 1'b1;
            end
        end
        if (hit_drive && drv_q.pend) begin
            drv_d.pd   = ~drv_q.shadow;
            drv_d.pend = 1'b0;
        end
    end

    // Falling edge: serial capture and pin drive
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drv_q.shadow <= '1;
            drv_q.pend   <= 1'b0;
            drv_q.pd     <= '0;
        end else begin
            drv_q <= drv_d;
        end
    end

    assign pd_en = drv_q.pd;

endmodule

// File: rtl/serial_pio_bridge.sv
`timescale 1ns/1ps
module serial_pio_bridge #(
    parameter int IDX_W       = 6,
    parameter int NPIO        = 2,
    parameter int SAMP_DATA   = spio_pkg::SAMP_DATA_DEF,
    parameter int SAMP_CTRL   = spio_pkg::SAMP_CTRL_DEF,
    parameter int WR_DATA_TOP = spio_pkg::WR_DATA_TOP_DEF,
    parameter int WR_CTRL_TOP = spio_pkg::WR_CTRL_TOP_DEF,
    parameter int DRV_DATA    = spio_pkg::DRV_DATA_DEF,
    parameter int DRV_CTRL    = spio_pkg::DRV_CTRL_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_mode,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             sdin,
    input  logic [NPIO-1:0]  pin_sense,
    output logic [NPIO-1:0]  pd_en,
    output logic [NPIO-1:0]  tx_pio
);
    logic            hit_samp;
    logic            hit_drive;
    logic [NPIO-1:0] hit_wr;

    spio_pos_decode #(
        .IDX_W      (IDX_W),
        .NPIO       (NPIO),
        .SAMP_DATA  (SAMP_DATA),
        .SAMP_CTRL  (SAMP_CTRL),
        .WR_DATA_TOP(WR_DATA_TOP),
        .WR_CTRL_TOP(WR_CTRL_TOP),
        .DRV_DATA   (DRV_DATA),
        .DRV_CTRL   (DRV_CTRL)
    ) i_decode (
        .ctrl_mode(ctrl_mode),
        .bit_idx  (bit_idx),
        .hit_samp (hit_samp),
        .hit_drive(hit_drive),
        .hit_wr   (hit_wr)
    );

    spio_pin_sampler #(
        .NPIO(NPIO)
    ) i_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (hit_samp),
        .pin_sense(pin_sense),
        .tx_pio   (tx_pio)
    );

    spio_shadow_drive #(
        .NPIO(NPIO)
    ) i_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_mode(ctrl_mode),
        .hit_wr   (hit_wr),
        .hit_drive(hit_drive),
        .sdin     (sdin),
        .pd_en    (pd_en)
    );

endmodule

// File: rtl/spio_bridge_checker.sv
`timescale 1ns/1ps
module spio_bridge_checker #(
    parameter int IDX_W     = 6,
    parameter int NPIO      = 2,
    parameter int SAMP_DATA = 20,
    parameter int SAMP_CTRL = 36,
    parameter int DRV_DATA  = 8,
    parameter int DRV_CTRL  = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctrl_mode,
    input logic [IDX_W-1:0] bit_idx,
    input logic [NPIO-1:0]  pin_sense,
    input logic [NPIO-1:0]  pd_en,
    input logic [NPIO-1:0]  tx_pio
);
    localparam logic [IDX_W-1:0] SD = IDX_W'(SAMP_DATA);
    localparam logic [IDX_W-1:0] SC = IDX_W'(SAMP_CTRL);
    localparam logic [IDX_W-1:0] DD = IDX_W'(DRV_DATA);
    localparam logic [IDX_W-1:0] DC = IDX_W'(DRV_CTRL);

    logic at_samp, at_drv;
    assign at_samp = (bit_idx == (ctrl_mode ? SC : SD));
    assign at_drv  = (bit_idx == (ctrl_mode ? DC : DD));

    AST_RESET_RELEASED: assert property (@(posedge clk)
        !rst_n |-> (pd_en == '0 && tx_pio == '1)); // R1

    AST_SAMPLE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        at_samp |=> (tx_pio == $past(pin_sense))); // R2

    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !at_samp |=> $stable(tx_pio)); // R4

    AST_PD_HELD: assert property (@(negedge clk) disable iff (!rst_n)
        !at_drv |=> $stable(pd_en)); // R7

endmodule

bind serial_pio_bridge spio_bridge_checker #(
    .IDX_W    (IDX_W),
    .NPIO     (NPIO),
    .SAMP_DATA(SAMP_DATA),
    .SAMP_CTRL(SAMP_CTRL),
    .DRV_DATA (DRV_DATA),
    .DRV_CTRL (DRV_CTRL)
) i_spio_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_mode(ctrl_mode),
    .bit_idx  (bit_idx),
    .pin_sense(pin_sense),
    .pd_en    (pd_en),
    .tx_pio   (tx_pio)
);

// File: tb/test_serial_pio_bridge.sv
`timescale 1ns/1ps
module test_serial_pio_bridge;
    localparam int IDX_W = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             ctrl_mode;
    logic [IDX_W-1:0] bit_idx;
    logic             sdin;
    logic [1:0]       ext_pull;
    logic [1:0]       pin_sense;
    logic [1:0]       pd_en;
    logic [1:0]       tx_pio;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    // Open-drain pins with pull-up: low if the block or the external device pulls
    assign pin_sense = ~(pd_en | ext_pull);

    serial_pio_bridge i_serial_pio_bridge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_mode(ctrl_mode),
        .bit_idx  (bit_idx),
        .sdin     (sdin),
        .pin_sense(pin_sense),
        .pd_en    (pd_en),
        .tx_pio   (tx_pio)
    );

    typedef struct packed {
        logic       mode;
        logic [1:0] w;
        logic [1:0] ext;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b0, 2'b00, 2'b00},
        '{1'b0, 2'b10, 2'b00},
        '{1'b0, 2'b11, 2'b01},
        '{1'b0, 2'b11, 2'b00},
        '{1'b1, 2'b00, 2'b00},
        '{1'b1, 2'b01, 2'b10},
        '{1'b0, 2'b01, 2'b00},
        '{1'b1, 2'b10, 2'b11},
        '{1'b0, 2'b00, 2'b10},
        '{1'b0, 2'b11, 2'b11}
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    // One bit slot: inputs change 1 ns after the rising edge, result read after the falling edge
    task automatic slot(input int idx, input logic mode, input logic [1:0] w);
        int top;
        @(posedge clk);
        #1;
        top       = mode ? 31 : 15;
        bit_idx   = IDX_W'(idx);
        ctrl_mode = mode;
        sdin      = (idx == top) ? w[1] : ((idx == top - 1) ? w[0] : 1'b0);
        #3;
    endtask

    task automatic run(input logic mode, input logic [1:0] w, input int hi, input int lo);
        for (int i = hi; i >= lo; i--) begin
            slot(i, mode, w);
        end
    endtask

    initial begin
        logic [1:0] exp_pd;
        logic [1:0] exp_tx;
        rst_n     = 1'b1;
        bit_idx   = '0;
        ctrl_mode = 1'b0;
        sdin      = 1'b0;
        ext_pull  = 2'b00;
        #1 rst_n  = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pd_en", pd_en, 2'b00);
        chk("R1 reset tx_pio", tx_pio, 2'b11);
        @(posedge clk);
        #1 rst_n = 1'b1;
        #3;
        chk("R1 after release pd_en", pd_en, 2'b00);

        // Table of whole words, with a bench model of pins and samples
        exp_pd = 2'b00;
        for (int v = 0; v < 10; v++) begin
            ext_pull = VEC[v].ext;
            exp_tx   = ~(exp_pd | VEC[v].ext);
            if (!VEC[v].mode) exp_pd = ~VEC[v].w;
            run(VEC[v].mode, VEC[v].w, 63, 0);
            chk(VEC[v].mode ? "R3 control sample" : "R2 R8 data sample", tx_pio, exp_tx);
            chk(VEC[v].mode ? "R6 control ignored" : "R5 R8 data write", pd_en, exp_pd);
        end

        // R7: shadow holds until the drive slot (pd_en currently 00)
        run(1'b0, 2'b01, 63, 9);
        chk("R7 before drive slot", pd_en, 2'b00);
        slot(8, 1'b0, 2'b01);
        chk("R7 at drive slot", pd_en, 2'b10);
        run(1'b0, 2'b01, 7, 0);

        // R4: pins change after the sample slot; tx_pio keeps the sampled value
        ext_pull = 2'b00;
        run(1'b0, 2'b11, 63, 19);
        ext_pull = 2'b11;
        run(1'b0, 2'b11, 18, 0);
        chk("R4 hold after sample", tx_pio, 2'b01);
        chk("R8 written ones release", pd_en, 2'b00);

        // R9: pending data write driven at the control drive slot
        ext_pull = 2'b00;
        run(1'b0, 2'b10, 63, 10);
        chk("R9 not driven in cut word", pd_en, 2'b00);
        run(1'b1, 2'b00, 63, 25);
        chk("R9 before control drive slot", pd_en, 2'b00);
        slot(24, 1'b1, 2'b00);
        chk("R9 at control drive slot", pd_en, 2'b01);
        run(1'b1, 2'b00, 23, 0);
        chk("R6 control field ignored", pd_en, 2'b01);
        chk("R3 control sample", tx_pio, 2'b11);

        // R1: reset in the middle of operation
        ext_pull = 2'b10;
        @(posedge clk);
        #1 rst_n = 1'b0;
        #1;
        chk("R1 mid-run pd_en", pd_en, 2'b00);
        chk("R1 mid-run tx_pio", tx_pio, 2'b11);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule